// File: doc/BRIEF.md
# NAND Sector Hamming ECC Engine

This block watches the byte stream of one NAND main-area sector as it passes the controller. It builds a Hamming-style parity code from the byte positions and the bit positions of the stream. Software stores that code in the spare area on a program, and writes it back for comparison on a read. On a program (encode mode) software reads the accumulated code as one 32-bit word. On a read (decode mode) software writes the stored code into two compare registers. The block then classifies the mismatch between the stored code and the freshly computed one, and reports where a single flipped data bit sits.

An init pulse restarts accumulation at sector byte 0. A lock level freezes the code, so that later transfers such as spare-area bytes leave the result alone. The block only reports the location of a flipped bit. Repairing the data is left to software.

Top module: `nandSectorEcc`

With the default 512-byte sector, A = 9 address bits and the code is 24 bits wide (CODE_W = 2A+6).

## Requirements
- R1: An `eccInit` pulse clears the code accumulator, the sector byte index, the status word and `statusValid`. After the pulse, `parity` reads zero in bits [CODE_W-1:0].
- R2: While `eccLock` is low, each `dataValid` byte at sector index i updates the code, with A = log2(sector bytes). The code bit positions are as follows. Bits [A-1:0] hold the even-line parities and bits [2A-1:A] the odd-line parities. Bits [2A+2:2A] hold the even-column parities and bits [2A+5:2A+3] the odd-column parities. The XOR of the byte's bits toggles odd-line bit k when bit k of i is 1, and even-line bit k otherwise. Odd-column bit j is the XOR of all data bits whose bit number has bit j set, and even-column bit j covers the remaining data bits.
- R3: While `eccLock` is high, data bytes leave `parity` unchanged.
- R4: `parity` carries the code in bits [CODE_W-1:0] and ones in every bit above (bits [31:24] by default). Software takes the four bytes of the word least-significant first.
- R5: The first compare write holds stored code byte 0 in `cmpData[7:0]` and byte 1 in `cmpData[23:16]`. The second compare write holds byte 2 in `cmpData[7:0]` and byte 3 in `cmpData[23:16]`. The stored code is the low CODE_W bits of {byte3, byte2, byte1, byte0}.
- R6: In decode mode, `statusValid` is low in the cycle after the clock edge that captures `cmpWr1`, and high after the following edge. It is cleared by `cmpWr0` or `eccInit`.
- R7: When the stored code equals the computed code, the status class in `status[1:0]` is 0.
- R8: When the data holds exactly one flipped bit, the class is 1. `status[17:7]` gives the byte index within the sector and `status[6:4]` gives the bit number within the byte.
- R9: When exactly one bit of the stored code differs and the data is intact, the class is 3.
- R10: Any other nonzero mismatch gives class 2. This includes two flipped data bits.
- R11: In encode mode (`encMode` high), compare writes are ignored: neither `status` nor `statusValid` changes.
- R12: All `status` bits other than [1:0] are zero unless the class is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eccInit | input | 1 | One-cycle pulse: restart accumulation, clear status |
| eccLock | input | 1 | High freezes the code accumulator |
| encMode | input | 1 | 1 = encode (program), 0 = decode (read check) |
| dataValid | input | 1 | A sector byte is present on dataByte |
| dataByte | input | 8 | Sector data byte |
| parity | output | 32 | Computed code with ones above CODE_W |
| cmpWr0 | input | 1 | Write strobe for stored code bytes 0 and 1 |
| cmpWr1 | input | 1 | Write strobe for stored code bytes 2 and 3; starts the evaluation |
| cmpData | input | 32 | Compare write data |
| status | output | 32 | Class [1:0], bit number [6:4], byte index [17:7] |
| statusValid | output | 1 | Status word holds a fresh result |

## Verification
The hardest case to reach is a class-1 result at every byte and bit position, because each one needs a whole sector streamed with one bit inverted. The bench therefore uses a 16-byte sector configuration. It first encodes a clean page, then replays the page once for every one of its 128 data bits with that single bit flipped. Each replay feeds back the clean code, so every position is covered. Code-bit flips and paired data flips are swept in the same way to reach classes 3 and 2.

// File: rtl/nandEccPkg.sv
package nandEccPkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic clrAcc;    // restart accumulation, clear status
    logic accum;     // fold dataByte into the code
    logic loadCmp0;  // capture stored code bytes 0/1
    logic loadCmp1;  // capture stored code bytes 2/3
    logic evaluate;  // register the classified status
  } eccStrobes_t;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_MULTI  = 2'd2,
    ERR_CODE   = 2'd3
  } eccClass_e;

endpackage

// File: rtl/nandEccCtrl.sv
module nandEccCtrl
  import nandEccPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        eccInit,
  input  logic        eccLock,
  input  logic        encMode,
  input  logic        dataValid,
  input  logic        cmpWr0,
  input  logic        cmpWr1,
  output eccStrobes_t strobes,
  output logic        statusValid
);

  logic evalPend;

  always_comb begin
    strobes.clrAcc   = eccInit;
    strobes.accum    = dataValid && !eccLock && !eccInit;
    strobes.loadCmp0 = cmpWr0 && !encMode;
    strobes.loadCmp1 = cmpWr1 && !encMode;
    strobes.evaluate = evalPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evalPend    <= 1'b0;
      statusValid <= 1'b0;
    end else begin
      evalPend <= strobes.loadCmp1 && !eccInit;
      if (eccInit || strobes.loadCmp0)
        statusValid <= 1'b0;
      else if (evalPend)
        statusValid <= 1'b1;
    end
  end

  // R6
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusValid) |-> $past(cmpWr1 && !encMode, 2));

  // R11
  enc_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (encMode && cmpWr1 && !evalPend) |=> !evalPend);

endmodule

// File: rtl/nandEccDatapath.sv
module nandEccDatapath
  import nandEccPkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  eccStrobes_t strobes,
  input  logic [7:0]  dataByte,
  input  logic [31:0] cmpData,
  output logic [31:0] parity,
  output logic [31:0] status
);

  localparam int ADDR_W  = $clog2(SECTOR_BYTES);
  localparam int CODE_W  = 2 * ADDR_W + 6;
  localparam int LODD_LO = ADDR_W;
  localparam int CEVN_LO = 2 * ADDR_W;
  localparam int CODD_LO = 2 * ADDR_W + 3;
  localparam int BYTE_LO = 7;

  logic [ADDR_W-1:0] byteIdx;
  logic [CODE_W-1:0] code, nextCode;
  logic [15:0]       cmpLo, cmpHi;
  logic [31:0]       storedWord;
  logic [CODE_W-1:0] syndrome;
  logic [ADDR_W-1:0] lineDiff;
  logic [2:0]        colDiff;
  logic              isSingle;
  logic [31:0]       statusNext;

  function automatic logic [7:0] colMask(input int j);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> j) & 1) == 1;
    return m;
  endfunction

  // Fold the incoming byte into line and column parities
  always_comb begin
    logic bytePar;
    nextCode = code;
    bytePar  = ^dataByte;
    for (int k = 0; k < ADDR_W; k++) begin
      if (byteIdx[k]) nextCode[LODD_LO+k] = nextCode[LODD_LO+k] ^ bytePar;
      else            nextCode[k]         = nextCode[k] ^ bytePar;
    end
    for (int j = 0; j < 3; j++) begin
      nextCode[CODD_LO+j] = nextCode[CODD_LO+j] ^ (^(dataByte & colMask(j)));
      nextCode[CEVN_LO+j] = nextCode[CEVN_LO+j] ^ (^(dataByte & ~colMask(j)));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code    <= '0;
      byteIdx <= '0;
    end else if (strobes.clrAcc) begin
      code    <= '0;
      byteIdx <= '0;
    end else if (strobes.accum) begin
      code    <= nextCode;
      byteIdx <= byteIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpLo <= '0;
      cmpHi <= '0;
    end else begin
      if (strobes.loadCmp0) cmpLo <= {cmpData[23:16], cmpData[7:0]};
      if (strobes.loadCmp1) cmpHi <= {cmpData[23:16], cmpData[7:0]};
    end
  end

  assign storedWord = {cmpHi, cmpLo};
  assign syndrome   = storedWord[CODE_W-1:0] ^ code;
  assign lineDiff   = syndrome[ADDR_W-1:0] ^ syndrome[LODD_LO +: ADDR_W];
  assign colDiff    = syndrome[CEVN_LO +: 3] ^ syndrome[CODD_LO +: 3];
  assign isSingle   = (&lineDiff) && (&colDiff);

  // Classify the mismatch
  always_comb begin
    statusNext = '0;
    if (syndrome == '0) begin
      statusNext[1:0] = ERR_NONE;
    end else if (isSingle) begin
      statusNext[1:0]               = ERR_SINGLE;
      statusNext[6:4]               = syndrome[CODD_LO +: 3];
      statusNext[BYTE_LO +: ADDR_W] = syndrome[LODD_LO +: ADDR_W];
    end else if ($countones(syndrome) == 1) begin
      statusNext[1:0] = ERR_CODE;
    end else begin
      statusNext[1:0] = ERR_MULTI;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 status <= '0;
    else if (strobes.clrAcc)   status <= '0;
    else if (strobes.evaluate) status <= statusNext;
  end

  assign parity = {{(32-CODE_W){1'b1}}, code};

  // R12
  loc_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status[1:0] != ERR_SINGLE) |-> (status[31:2] == '0));

  // R8
  byte_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status[1:0] == ERR_SINGLE) |-> (status[17:7] < 11'(SECTOR_BYTES)));

endmodule

// File: rtl/nandSectorEcc.sv
module nandSectorEcc
  import nandEccPkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        eccInit,
  input  logic        eccLock,
  input  logic        encMode,
  input  logic        dataValid,
  input  logic [7:0]  dataByte,
  output logic [31:0] parity,
  input  logic        cmpWr0,
  input  logic        cmpWr1,
  input  logic [31:0] cmpData,
  output logic [31:0] status,
  output logic        statusValid
);

  localparam int ADDR_W = $clog2(SECTOR_BYTES);
  localparam int CODE_W = 2 * ADDR_W + 6;

  eccStrobes_t strobes;

  nandEccCtrl uCtrl (
    .clk(clk), .rstN(rstN), .eccInit(eccInit), .eccLock(eccLock),
    .encMode(encMode), .dataValid(dataValid), .cmpWr0(cmpWr0),
    .cmpWr1(cmpWr1), .strobes(strobes), .statusValid(statusValid)
  );

  nandEccDatapath #(.SECTOR_BYTES(SECTOR_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataByte(dataByte),
    .cmpData(cmpData), .parity(parity), .status(status)
  );

  // R1
  init_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    eccInit |=> (parity[CODE_W-1:0] == '0) && !statusValid);

  // R3
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eccLock && !eccInit) |=> $stable(parity));

endmodule

// File: tb/tb_nandSectorEcc.sv
module tb_nandSectorEcc;

  localparam int SB = 16;
  localparam int A  = $clog2(SB);
  localparam int CW = 2 * A + 6;
  localparam logic [31:0] ONES_HI = ~((32'd1 << CW) - 32'd1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eccInit = 1'b0, eccLock = 1'b0, encMode = 1'b0, dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic cmpWr0 = 1'b0, cmpWr1 = 1'b0;
  logic [31:0] cmpData = '0;
  logic [31:0] parity, status;
  logic statusValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] page [SB];
  logic [7:0] rx [SB];

  always #2 clk = ~clk;

  nandSectorEcc #(.SECTOR_BYTES(SB)) dut (
    .clk(clk), .rstN(rstN), .eccInit(eccInit), .eccLock(eccLock),
    .encMode(encMode), .dataValid(dataValid), .dataByte(dataByte),
    .parity(parity), .cmpWr0(cmpWr0), .cmpWr1(cmpWr1), .cmpData(cmpData),
    .status(status), .statusValid(statusValid)
  );

  function automatic logic [CW-1:0] modelCode(input logic [7:0] d [SB]);
    logic [CW-1:0] c = '0;
    for (int i = 0; i < SB; i++) begin
      logic bp = ^d[i];
      for (int k = 0; k < A; k++) begin
        if (((i >> k) & 1) == 1) c[A+k] ^= bp;
        else                     c[k]   ^= bp;
      end
      for (int j = 0; j < 3; j++)
        for (int b = 0; b < 8; b++) begin
          if (((b >> j) & 1) == 1) c[2*A+3+j] ^= d[i][b];
          else                     c[2*A+j]   ^= d[i][b];
        end
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseInit();
    @(negedge clk) eccInit = 1'b1; eccLock = 1'b0;
    @(negedge clk) eccInit = 1'b0;
  endtask

  task automatic streamRx();
    for (int i = 0; i < SB; i++) begin
      @(negedge clk) dataValid = 1'b1; dataByte = rx[i];
    end
    @(negedge clk) dataValid = 1'b0;
  endtask

  // R5: byte 0 in [7:0], byte 1 in [23:16]; then bytes 2 and 3
  task automatic writeCmp(input logic [31:0] w, input bit chkTiming);
    @(negedge clk) cmpWr0 = 1'b1; cmpData = {8'h00, w[15:8], 8'h00, w[7:0]};
    @(negedge clk) cmpWr0 = 1'b0; cmpWr1 = 1'b1;
    cmpData = {8'h00, w[31:24], 8'h00, w[23:16]};
    @(negedge clk) cmpWr1 = 1'b0;
    if (chkTiming) check("R6 valid low after write", 32'(statusValid), 32'd0);
    @(negedge clk);
    if (chkTiming) check("R6 valid high", 32'(statusValid), 32'd1);
  endtask

  task automatic decodeCase(input logic [31:0] stored, input logic [31:0] exp, input string req);
    pulseInit();
    encMode = 1'b0;
    streamRx();
    eccLock = 1'b1;
    writeCmp(stored, 1'b1);
    check(req, status, exp);
    eccLock = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] good;
    logic [31:0] goodWord;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset parity", parity, ONES_HI);
    check("R1 reset valid", 32'(statusValid), 32'd0);
    check("R1 reset status", status, 32'd0);

    // Encode sweeps over several page patterns (R2, R4)
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < SB; i++) page[i] = 8'((i * 37 + s * 91 + (i >> 2) * s) ^ (s * 13));
      if (s == 1) for (int i = 0; i < SB; i++) page[i] = 8'hFF;
      if (s == 2) for (int i = 0; i < SB; i++) page[i] = 8'h00;
      rx = page;
      pulseInit();
      check("R1 init parity", parity, ONES_HI);
      encMode = 1'b1;
      streamRx();
      check("R2 R4 encode parity", parity, ONES_HI | 32'(modelCode(page)));
      // R3: locked bytes must not move the code
      eccLock = 1'b1;
      for (int i = 0; i < SB; i++) rx[i] = 8'(i * 5 + 1);
      streamRx();
      check("R3 lock freeze", parity, ONES_HI | 32'(modelCode(page)));
      // R11: compare writes ignored in encode mode
      writeCmp(32'h00AB_CD12, 1'b0);
      check("R11 valid unchanged", 32'(statusValid), 32'd0);
      check("R11 status unchanged", status, 32'd0);
      eccLock = 1'b0;
    end

    // Decode: clean page
    for (int i = 0; i < SB; i++) page[i] = 8'((i * 53) ^ 8'h5A);
    good = modelCode(page);
    goodWord = ONES_HI | 32'(good);
    rx = page;
    decodeCase(goodWord, 32'd0, "R7 no error");

    // R8: every single data bit
    for (int i = 0; i < SB; i++)
      for (int b = 0; b < 8; b++) begin
        rx = page;
        rx[i][b] = ~rx[i][b];
        decodeCase(goodWord, (32'(i) << 7) | (32'(b) << 4) | 32'd1, "R8 single bit");
      end

    // R9 R12: every single code bit
    for (int c = 0; c < CW; c++) begin
      rx = page;
      decodeCase(goodWord ^ (32'd1 << c), 32'd3, "R9 R12 code bit");
    end

    // R10 R12: paired data flips
    for (int p = 0; p < SB * 8; p += 5) begin
      int q = (p * 7 + 3) % (SB * 8);
      if (q == p) q = (q + 1) % (SB * 8);
      rx = page;
      rx[p / 8][p % 8] = ~rx[p / 8][p % 8];
      rx[q / 8][q % 8] = ~rx[q / 8][q % 8];
      decodeCase(goodWord, 32'd2, "R10 R12 double bit");
    end

    // R1: init after a result clears status and valid
    rx = page;
    rx[3][6] = ~rx[3][6];
    decodeCase(goodWord, (32'd3 << 7) | (32'd6 << 4) | 32'd1, "R8 before init");
    pulseInit();
    check("R1 init clears valid", 32'(statusValid), 32'd0);
    check("R1 init clears status", status, 32'd0);
    check("R1 init clears code", parity, ONES_HI);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule